// File: doc/BRIEF.md
# USB Hub Downstream Port Power Controller

This block manages power permission and overcurrent status for the four downstream ports of a USB hub. Software reaches one 8-bit control register through a small indexed register interface: an address, a write strobe, write data and a combinational read-data bus. The register holds the hub's active-low run/reset control, a two-bit port-count code and a ganged-power selector.

The port-count code decides which ports exist for this board. Its default comes from two active-low strap pins sampled while the power-on reset is asserted: each register bit is the inverse of its pin, so unconnected (high) straps give code 00, meaning all four ports. A port outside the selected count has its active-low power enable driven low and its overcurrent input ignored. Each overcurrent pin passes through a two-flop synchronizer before use. In ganged mode port 1's sense input stands for all ports, and one combined power request drives every enabled port's enable output.

Register layout at index 0xF7: bit 0 = hub run (0 holds the hub in reset), bit 1 = ganged mode, bits 3:2 = port-count code, bits 7:4 reserved.

Top module: `usb_port_pwr_ctl`

## Requirements
- R1: While rst_n is low the control register loads bits 3:2 with the inverse of strap_n[1:0] and all other bits with 0, so strap_n = 2'b11 gives a read value of 0x00 and strap_n = 2'b10 gives 0x04.
- R2: A read at index 0xF7 returns the control register; a read at any other index returns 0x00, and a write with any other index leaves the register unchanged.
- R3: Bits 7:4 of the register always read 0; a write of 1s to them has no effect.
- R4: hub_ready equals register bit 0, one cycle after the write that sets or clears it.
- R5: port_enabled follows bits 3:2: 00 = 4'b1111, 01 = 4'b0011, 10 = 4'b0111, 11 (reserved) = 4'b1111.
- R6: While register bit 0 is 0, every bit of pwr_en_n is 1, whatever the other settings and requests.
- R7: With bit 0 = 1 and bit 1 = 0, each enabled port drives pwr_en_n[i] = ~pwr_req[i].
- R8: With bit 0 = 1, a port not enabled by the port-count code drives pwr_en_n[i] = 0, and its port_oc[i] is 0 in every mode.
- R9: port_oc[i] of an enabled port in independent mode equals ~oc_n[i] as it was two clock edges earlier.
- R10: With bits 0 and 1 both 1, every enabled port drives pwr_en_n = ~(OR of pwr_req over enabled ports), and every enabled port reports port_oc = ~oc_n[0] (synchronized).
- R11: Changes on strap_n after reset has been released have no effect on the register or on port_enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low power-on reset; strap pins are sampled while it is low |
| strap_n | input | 2 | Active-low port-count strap pins |
| reg_addr | input | 8 | Register index |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| pwr_req | input | 4 | Per-port power request from the hub logic, active high |
| oc_n | input | 4 | Asynchronous active-low overcurrent sense pins |
| hub_ready | output | 1 | Hub released from reset |
| port_enabled | output | 4 | Port exists under the current port-count code |
| pwr_en_n | output | 4 | Active-low port power enables |
| port_oc | output | 4 | Synchronized overcurrent status per enabled port, active high |

## Verification
The assertions assume that oc_n is sampled only through the synchronizer, so the two-edge delay of R9 is measured from the clock edges and only after two cycles out of reset, and that strap_n matters only during reset. The stimulus holds each random oc_n pattern for several cycles before checking, changes strap_n only around reset pulses except in the directed R11 case, and issues register writes as single-cycle strobes between checks.

// File: rtl/usb_pwr_pkg.sv
package usb_pwr_pkg;
  localparam int NPORTS     = 4;
  localparam int REG_W      = 8;
  localparam int RUN_BIT    = 0;
  localparam int GANG_BIT   = 1;
  localparam int CNT_LSB    = 2;
  localparam int CNT_W      = 2;
  localparam logic [REG_W-1:0] WR_MASK = 8'h0F;

  typedef enum logic [CNT_W-1:0] {
    CNT_FOUR  = 2'b00,
    CNT_TWO   = 2'b01,
    CNT_THREE = 2'b10,
    CNT_RSVD  = 2'b11
  } port_cnt_e;

  // Port-count code to enabled-port mask.
  function automatic logic [NPORTS-1:0] ports_of(input logic [CNT_W-1:0] code);
    case (port_cnt_e'(code))
      CNT_TWO:   return 4'b0011;
      CNT_THREE: return 4'b0111;
      default:   return 4'b1111;
    endcase
  endfunction

  // Active-low enable outputs from the settings and requests.
  function automatic logic [NPORTS-1:0] enables_of(
      input logic              run,
      input logic              gang,
      input logic [NPORTS-1:0] en,
      input logic [NPORTS-1:0] req);
    logic [NPORTS-1:0] act;
    if (!run) return '1;
    if (gang) act = {NPORTS{|(req & en)}};
    else      act = req;
    return ~act & en;
  endfunction

  // Active-high overcurrent status from synchronized active-low sense.
  function automatic logic [NPORTS-1:0] oc_of(
      input logic              gang,
      input logic [NPORTS-1:0] en,
      input logic [NPORTS-1:0] sense_n);
    logic [NPORTS-1:0] oc;
    if (gang) oc = {NPORTS{~sense_n[0]}};
    else      oc = ~sense_n;
    return oc & en;
  endfunction
endpackage

// File: rtl/usb_pwr_regfile.sv
module usb_pwr_regfile
  import usb_pwr_pkg::*;
#(
  parameter logic [7:0] REG_INDEX = 8'hF7,
  parameter int         ADDR_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  strap_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic [REG_W-1:0]  ctl
);
  logic hit;
  logic [REG_W-1:0] ctl_q;
  logic [REG_W-1:0] reset_val;

  assign hit = (reg_addr == ADDR_W'(REG_INDEX));

  always_comb begin
    reset_val = '0;
    reset_val[CNT_LSB +: CNT_W] = ~strap_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           ctl_q <= reset_val;
    else if (reg_wr && hit) ctl_q <= reg_wdata & WR_MASK;
  end

  assign ctl       = ctl_q;
  assign reg_rdata = hit ? ctl_q : '0;
endmodule

// File: rtl/usb_oc_sync.sv
module usb_oc_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din_n,
  output logic [WIDTH-1:0] dout_n
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) stg[k] <= '1;
    end else begin
      stg[0] <= din_n;
      for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
    end
  end

  assign dout_n = stg[STAGES-1];
endmodule

// File: rtl/usb_pwr_route.sv
module usb_pwr_route
  import usb_pwr_pkg::*;
(
  input  logic [REG_W-1:0]  ctl,
  input  logic [NPORTS-1:0] pwr_req,
  input  logic [NPORTS-1:0] sense_n,
  output logic              run,
  output logic              gang,
  output logic [NPORTS-1:0] port_enabled,
  output logic [NPORTS-1:0] pwr_en_n,
  output logic [NPORTS-1:0] port_oc
);
  assign run          = ctl[RUN_BIT];
  assign gang         = ctl[GANG_BIT];
  assign port_enabled = ports_of(ctl[CNT_LSB +: CNT_W]);
  assign pwr_en_n     = enables_of(run, gang, port_enabled, pwr_req);
  assign port_oc      = oc_of(gang, port_enabled, sense_n);
endmodule

// File: rtl/usb_port_pwr_ctl.sv
module usb_port_pwr_ctl
  import usb_pwr_pkg::*;
#(
  parameter logic [7:0] REG_INDEX   = 8'hF7,
  parameter int         ADDR_W      = 8,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        strap_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic [3:0]        pwr_req,
  input  logic [3:0]        oc_n,
  output logic              hub_ready,
  output logic [3:0]        port_enabled,
  output logic [3:0]        pwr_en_n,
  output logic [3:0]        port_oc
);
  logic [REG_W-1:0]  ctl;
  logic [NPORTS-1:0] sense_n;
  logic              run;
  logic              gang_mode;

  usb_pwr_regfile #(.REG_INDEX(REG_INDEX), .ADDR_W(ADDR_W)) regs_i (
    .clk, .rst_n, .strap_n, .reg_addr, .reg_wr, .reg_wdata, .reg_rdata, .ctl
  );

  usb_oc_sync #(.WIDTH(NPORTS), .STAGES(SYNC_STAGES)) sync_i (
    .clk, .rst_n, .din_n(oc_n), .dout_n(sense_n)
  );

  usb_pwr_route route_i (
    .ctl, .pwr_req, .sense_n, .run, .gang(gang_mode),
    .port_enabled, .pwr_en_n, .port_oc
  );

  assign hub_ready = run;
endmodule

// File: rtl/usb_port_pwr_ctl_chk.sv
module usb_port_pwr_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] reg_addr,
  input logic       reg_wr,
  input logic [7:0] reg_rdata,
  input logic [3:0] oc_n,
  input logic       hub_ready,
  input logic       gang_mode,
  input logic [3:0] port_enabled,
  input logic [3:0] pwr_en_n,
  input logic [3:0] port_oc
);
  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[7:4] == 4'h0);

  a_r5_port1_always: assert property (@(posedge clk) disable iff (!rst_n)
    port_enabled[0] && (port_enabled[3] -> port_enabled[2]) && (port_enabled[2] -> port_enabled[1]));

  a_r6_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
    !hub_ready |-> pwr_en_n == 4'hF);

  a_r8_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    hub_ready |-> ((pwr_en_n & ~port_enabled) == 4'h0) && ((port_oc & ~port_enabled) == 4'h0));

  a_r9_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2) |-> port_oc[0] == !$past(oc_n[0], 2));

  a_r10_gang_uniform: assert property (@(posedge clk) disable iff (!rst_n)
    (hub_ready && gang_mode) |->
      (((pwr_en_n & port_enabled) == 4'h0) || ((pwr_en_n & port_enabled) == port_enabled)));

  a_r11_cnt_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (age != 2'd0) && !(reg_wr && reg_addr == 8'hF7) |=> $stable(port_enabled));
endmodule

bind usb_port_pwr_ctl usb_port_pwr_ctl_chk chk_i (.*);

// File: tb/usb_port_pwr_ctl_tb_top.sv
module usb_port_pwr_ctl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] strap_n = 2'b11;
  logic [7:0] reg_addr = 8'h00;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic [3:0] pwr_req = 4'h0;
  logic [3:0] oc_n = 4'hF;
  logic       hub_ready;
  logic [3:0] port_enabled, pwr_en_n, port_oc;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] shadow;

  always #2 clk = ~clk;

  usb_port_pwr_ctl dut_i (.*);

  function automatic logic [3:0] m_en(input logic [1:0] c);
    if (c == 2'b01) return 4'b0011;
    if (c == 2'b10) return 4'b0111;
    return 4'b1111;
  endfunction

  function automatic logic [3:0] m_pwr(input logic [7:0] r, input logic [3:0] q);
    logic [3:0] e, o;
    e = m_en(r[3:2]);
    if (!r[0]) return 4'hF;
    for (int i = 0; i < 4; i++)
      o[i] = e[i] ? (r[1] ? ~|(q & e) : ~q[i]) : 1'b0;
    return o;
  endfunction

  function automatic logic [3:0] m_oc(input logic [7:0] r, input logic [3:0] s);
    logic [3:0] e;
    e = m_en(r[3:2]);
    return (r[1] ? {4{~s[0]}} : ~s) & e;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 8'hF7;
  endtask

  task automatic do_reset(input logic [1:0] s);
    @(negedge clk);
    strap_n = s; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic check_all(input string tag);
    reg_addr = 8'hF7; #0.1;
    chk({tag, " R2 read"}, reg_rdata, shadow);
    chk({tag, " R5 enabled"}, port_enabled, m_en(shadow[3:2]));
    chk({tag, " R7/R10 pwr"}, pwr_en_n, m_pwr(shadow, pwr_req));
    chk({tag, " R9/R10 oc"}, port_oc, m_oc(shadow, oc_n));
  endtask

  initial begin
    // R1: strap sampling at reset
    do_reset(2'b10);
    reg_addr = 8'hF7; #0.1;
    chk("R1 strap 10", reg_rdata, 8'h04);
    chk("R5 two ports", port_enabled, 4'b0011);
    chk("R6 reset hold", pwr_en_n, 4'hF);
    chk("R4 not ready", hub_ready, 1'b0);
    do_reset(2'b11);
    reg_addr = 8'hF7; #0.1;
    chk("R1 strap 11", reg_rdata, 8'h00);
    // R11: strap change after reset ignored
    @(negedge clk); strap_n = 2'b00;
    repeat (2) @(negedge clk);
    chk("R11 strap ignored", {reg_rdata, port_enabled}, {8'h00, 4'b1111});
    // R2: other index
    wr(8'h10, 8'h0F);
    chk("R2 wrong index write", reg_rdata, 8'h00);
    reg_addr = 8'h10; #0.1;
    chk("R2 other read", reg_rdata, 8'h00);
    // R3/R4
    wr(8'hF7, 8'hF1); shadow = 8'h01;
    chk("R3 reserved", reg_rdata, 8'h01);
    chk("R4 ready", hub_ready, 1'b1);
    // R8 disabled ports, code 01 (two ports)
    pwr_req = 4'hF; oc_n = 4'h0;
    wr(8'hF7, 8'h05); shadow = 8'h05;
    repeat (2) @(negedge clk);
    chk("R8 disabled low", pwr_en_n, 4'b1100 & 4'b0000);
    chk("R8 oc ignored", port_oc, 4'b0011);
    // R9 two-edge delay
    oc_n = 4'hF; wr(8'hF7, 8'h01); shadow = 8'h01;
    @(negedge clk); oc_n = 4'b1110;
    @(negedge clk);
    chk("R9 after one edge", port_oc, 4'b0000);
    @(negedge clk);
    chk("R9 after two edges", port_oc, 4'b0001);
    // R10 gang, three ports, request only on port 3
    pwr_req = 4'b0100; oc_n = 4'b1110;
    wr(8'hF7, 8'h0B); shadow = 8'h0B;
    repeat (2) @(negedge clk);
    chk("R10 gang pwr", pwr_en_n, 4'b0000);
    chk("R10 gang oc", port_oc, 4'b0111);
    pwr_req = 4'b1000; #0.1;
    chk("R10 gang disabled req", pwr_en_n, 4'b0111);
    // R6 reset bit cleared overrides
    wr(8'hF7, 8'h02); shadow = 8'h02; pwr_req = 4'hF; #0.1;
    chk("R6 hold off", pwr_en_n, 4'hF);
    chk("R4 cleared", hub_ready, 1'b0);
    // random
    void'($urandom(32'd1234));
    for (int n = 0; n < 300; n++) begin
      logic [7:0] d;
      d = 8'($urandom);
      wr(8'hF7, d); shadow = d & 8'h0F;
      @(negedge clk);
      pwr_req = 4'($urandom); oc_n = 4'($urandom);
      repeat (3) @(negedge clk);
      check_all("rand");
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule